// File: doc/BRIEF.md
# Write-Through Cache Cycle Qualifier

This block sits between a 32-bit processor bus and a slower system bus. It holds a direct-mapped cache of single-word lines. When the processor starts a cycle, the block sorts it in that same clock. A cycle is either local, in which case it is dropped. Otherwise it is cacheable or uncached, and a cacheable cycle is then either a hit or a miss. A cacheable read that hits is answered in the same clock from the data array. Every other cycle that is not local goes to the system bus as one request. The request is held until the system acknowledges it, and the processor cycle ends in the same clock as that acknowledge.

A cacheable read miss fetches the whole word from the system bus and writes it into the line. Writes always go out to memory. A write that hits also merges its enabled bytes into the cached line, and a write that misses allocates nothing. Two decode inputs let the surrounding system mark a cycle as uncached or as local. Reset and a flush strobe empty the directory.

Top module: `wt_cache_qualifier`

## Requirements
- R1: A memory read (`cpu_kind` = 2'b00) that is not marked uncached or local, and whose word is valid in the directory with a matching tag, raises `cpu_done` in the same cycle as `cpu_req`. `cpu_rdata` then carries the cached word, and `sys_req` stays low afterwards.
- R2: A cacheable memory read that misses raises `sys_req` one cycle after `cpu_req`, with `sys_be` = 4'hF and `sys_wr` low. In the cycle of `sys_ack`, `cpu_done` is high and `cpu_rdata` equals `sys_rdata`. The word and its tag are written into the line, so the next read of that word is a hit.
- R3: Every forwarded cycle other than a cacheable read miss presents `sys_be` equal to the `cpu_be` given with the request. `sys_addr`, `sys_wr` and `sys_kind` copy the processor cycle.
- R4: A memory read with `dec_nocache` high is forwarded like a miss, even when its word is cached. It leaves the data and the directory unchanged, so a later cacheable read of the same word still misses if it was not cached, and still hits with the old data if it was.
- R5: Cycles of kind I/O (2'b01), interrupt acknowledge (2'b10) and halt/shutdown (2'b11) are always forwarded and never fill or update the cache, whatever the decode inputs say, except that `dec_local` still applies.
- R6: A cycle with `dec_local` high is ignored. `cpu_done` and `sys_req` stay low, and the cache contents are unchanged.
- R7: Every write that is not local is forwarded and never ends before `sys_ack`. A write hit merges the bytes enabled in `cpu_be` into the cached word. A write miss allocates no line.
- R8: Reset and a one-cycle `flush` pulse each clear all valid bits, so the first cacheable read after either one misses.
- R9: While `sys_req` is high and `sys_ack` is low, `sys_req`, `sys_addr`, `sys_be` and `sys_wr` hold their values. `sys_req` and `sys_ack` together raise `cpu_done`.
- R10: The line index is word-address bits [IDX_W+1:2] and the tag is the bits above them. A fill for another tag at the same index evicts the line that was there.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| flush | input | 1 | Clears every valid bit |
| cpu_req | input | 1 | Start of a processor cycle, accepted only while no system request is open |
| cpu_addr | input | ADDR_W | Processor byte address |
| cpu_wr | input | 1 | 1 = write |
| cpu_kind | input | 2 | 00 memory, 01 I/O, 10 interrupt ack, 11 halt/shutdown |
| cpu_be | input | DATA_W/8 | Processor byte enables |
| cpu_wdata | input | DATA_W | Write data |
| dec_nocache | input | 1 | External decode: cycle is uncached |
| dec_local | input | 1 | External decode: cycle is local, ignore it |
| cpu_done | output | 1 | Processor cycle ends this clock |
| cpu_rdata | output | DATA_W | Read data to the processor |
| sys_req | output | 1 | System bus request, held until acknowledge |
| sys_addr | output | ADDR_W | System address |
| sys_wr | output | 1 | System write |
| sys_kind | output | 2 | Cycle kind forwarded |
| sys_be | output | DATA_W/8 | System byte enables |
| sys_wdata | output | DATA_W | System write data |
| sys_ack | input | 1 | System acknowledge |
| sys_rdata | input | DATA_W | System read data |

## Verification
Directed sequences drive the cases that are easy to confuse. A read is followed by the same read, to tell a fill from a pass-through. An uncached or I/O read of a cached word must not disturb the line. Partial writes are followed by reads, to show the byte merge. A write miss is followed by a read of the old tag, to show that no line was allocated. Two tags at one index show eviction, and flush or reset followed by a read shows the directory was cleared. Random cycles over a small pool of tags and indices then mix kinds, decode flags and acknowledge delays, so hits, misses and evictions occur often. Each one is checked against a bench model of the directory and of memory.

// File: rtl/wtq_pkg.sv
package wtq_pkg;
   typedef enum logic [1:0] {
      CK_MEM  = 2'b00,
      CK_IO   = 2'b01,
      CK_INTA = 2'b10,
      CK_HALT = 2'b11
   } cyc_kind_e;

   typedef enum logic {
      SQ_IDLE = 1'b0,
      SQ_BUS  = 1'b1
   } seq_state_e;

   typedef struct packed {
      logic is_local;
      logic cacheable;
      logic forward;
      logic zero_wait;
   } cyc_class_t;
endpackage

// File: rtl/wtq_classify.sv
module wtq_classify
   import wtq_pkg::*;
(
   input  logic       [1:0] kind,
   input  logic             wr,
   input  logic             nocache_dec,
   input  logic             local_dec,
   input  logic             hit,
   output cyc_class_t       cls
);
   logic is_mem;

   always_comb begin
      is_mem        = (cyc_kind_e'(kind) == CK_MEM);
      cls.is_local  = local_dec;
      // only plain memory space may be cached; decode can veto it
      cls.cacheable = is_mem && !nocache_dec && !local_dec;
      // hit result counts only for cacheable reads
      cls.zero_wait = cls.cacheable && !wr && hit;
      cls.forward   = !local_dec && !cls.zero_wait;
   end
endmodule

// File: rtl/wtq_directory.sv
module wtq_directory #(
   parameter int ENTRIES = 16,
   parameter int WADDR_W = 30,
   parameter int DATA_W  = 32,
   localparam int IDX_W  = $clog2(ENTRIES),
   localparam int TAG_W  = WADDR_W - IDX_W,
   localparam int LANES  = DATA_W / 8
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               flush,
   input  logic [WADDR_W-1:0] lk_waddr,
   output logic               hit,
   output logic [DATA_W-1:0]  lk_data,
   input  logic               fill_en,
   input  logic               upd_en,
   input  logic [WADDR_W-1:0] wr_waddr,
   input  logic [DATA_W-1:0]  wr_data,
   input  logic [LANES-1:0]   wr_be
);
   logic [ENTRIES-1:0] valid_q;
   logic [TAG_W-1:0]   tag_q  [ENTRIES];
   logic [DATA_W-1:0]  data_q [ENTRIES];

   logic [IDX_W-1:0]   lk_idx, wr_idx;
   logic [TAG_W-1:0]   lk_tag, wr_tag;
   logic [DATA_W-1:0]  merged;

   assign lk_idx = lk_waddr[IDX_W-1:0];
   assign lk_tag = lk_waddr[WADDR_W-1:IDX_W];
   assign wr_idx = wr_waddr[IDX_W-1:0];
   assign wr_tag = wr_waddr[WADDR_W-1:IDX_W];

   assign hit     = valid_q[lk_idx] && (tag_q[lk_idx] == lk_tag);
   assign lk_data = data_q[lk_idx];

   // per-lane merge: a fill takes every lane, an update only enabled ones
   for (genvar b = 0; b < LANES; b++) begin : g_lane
      assign merged[b*8 +: 8] = (fill_en || wr_be[b]) ? wr_data[b*8 +: 8]
                                                      : data_q[wr_idx][b*8 +: 8];
   end

   // flush has priority over a fill in the same cycle
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         valid_q <= '0;
      else if (flush)
         valid_q <= '0;
      else if (fill_en)
         valid_q[wr_idx] <= 1'b1;
   end

   always_ff @(posedge clk) begin
      if (fill_en)
         tag_q[wr_idx] <= wr_tag;
      if (fill_en || upd_en)
         data_q[wr_idx] <= merged;
   end
endmodule

// File: rtl/wtq_bus_seq.sv
module wtq_bus_seq
   import wtq_pkg::*;
#(
   parameter int ADDR_W = 32,
   parameter int DATA_W = 32,
   localparam int LANES = DATA_W / 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              accept,
   input  logic [ADDR_W-1:0] in_addr,
   input  logic              in_wr,
   input  logic [1:0]        in_kind,
   input  logic [LANES-1:0]  in_be,
   input  logic [DATA_W-1:0] in_wdata,
   input  logic              in_fill,
   input  logic              in_upd,
   input  logic              sys_ack,
   output logic              idle,
   output logic              sys_req,
   output logic [ADDR_W-1:0] sys_addr,
   output logic              sys_wr,
   output logic [1:0]        sys_kind,
   output logic [LANES-1:0]  sys_be,
   output logic [DATA_W-1:0] sys_wdata,
   output logic              bus_done,
   output logic              fill_en,
   output logic              upd_en
);
   seq_state_e state_q;
   logic       fill_q, upd_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         state_q <= SQ_IDLE;
      else if (state_q == SQ_IDLE && accept)
         state_q <= SQ_BUS;
      else if (state_q == SQ_BUS && sys_ack)
         state_q <= SQ_IDLE;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sys_addr  <= '0;
         sys_wr    <= 1'b0;
         sys_kind  <= '0;
         sys_be    <= '0;
         sys_wdata <= '0;
         fill_q    <= 1'b0;
         upd_q     <= 1'b0;
      end else if (state_q == SQ_IDLE && accept) begin
         sys_addr  <= in_addr;
         sys_wr    <= in_wr;
         sys_kind  <= in_kind;
         sys_be    <= in_be;
         sys_wdata <= in_wdata;
         fill_q    <= in_fill;
         upd_q     <= in_upd;
      end
   end

   assign idle     = (state_q == SQ_IDLE);
   assign sys_req  = (state_q == SQ_BUS);
   assign bus_done = sys_req && sys_ack;
   assign fill_en  = bus_done && fill_q;
   assign upd_en   = bus_done && upd_q;
endmodule

// File: rtl/wt_cache_qualifier.sv
module wt_cache_qualifier
   import wtq_pkg::*;
#(
   parameter int ENTRIES = 16,
   parameter int ADDR_W  = 32,
   parameter int DATA_W  = 32
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  flush,
   input  logic                  cpu_req,
   input  logic [ADDR_W-1:0]     cpu_addr,
   input  logic                  cpu_wr,
   input  logic [1:0]            cpu_kind,
   input  logic [DATA_W/8-1:0]   cpu_be,
   input  logic [DATA_W-1:0]     cpu_wdata,
   input  logic                  dec_nocache,
   input  logic                  dec_local,
   output logic                  cpu_done,
   output logic [DATA_W-1:0]     cpu_rdata,
   output logic                  sys_req,
   output logic [ADDR_W-1:0]     sys_addr,
   output logic                  sys_wr,
   output logic [1:0]            sys_kind,
   output logic [DATA_W/8-1:0]   sys_be,
   output logic [DATA_W-1:0]     sys_wdata,
   input  logic                  sys_ack,
   input  logic [DATA_W-1:0]     sys_rdata
);
   localparam int LANES   = DATA_W / 8;
   localparam int OFS_W   = $clog2(LANES);
   localparam int WADDR_W = ADDR_W - OFS_W;
   localparam int IDX_W   = $clog2(ENTRIES);

   initial begin
      if (ENTRIES < 2 || (ENTRIES & (ENTRIES - 1)) != 0)
         $fatal(1, "ENTRIES must be a power of two, at least 2");
      if (DATA_W < 16 || (DATA_W % 8) != 0 || (LANES & (LANES - 1)) != 0)
         $fatal(1, "DATA_W must be a power-of-two count of bytes");
      if (WADDR_W - IDX_W < 1)
         $fatal(1, "address too narrow for the directory");
   end

   cyc_class_t         cls;
   logic               hit, idle, bus_done, fill_en, upd_en, accept;
   logic [DATA_W-1:0]  lk_data, dir_wdata;
   logic [LANES-1:0]   fwd_be;

   wtq_directory #(
      .ENTRIES (ENTRIES),
      .WADDR_W (WADDR_W),
      .DATA_W  (DATA_W)
   ) dir_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .flush    (flush),
      .lk_waddr (cpu_addr[ADDR_W-1:OFS_W]),
      .hit      (hit),
      .lk_data  (lk_data),
      .fill_en  (fill_en),
      .upd_en   (upd_en),
      .wr_waddr (sys_addr[ADDR_W-1:OFS_W]),
      .wr_data  (dir_wdata),
      .wr_be    (sys_be)
   );

   wtq_classify cls_i (
      .kind        (cpu_kind),
      .wr          (cpu_wr),
      .nocache_dec (dec_nocache),
      .local_dec   (dec_local),
      .hit         (hit),
      .cls         (cls)
   );

   assign accept    = idle && cpu_req && cls.forward;
   // a line is one whole word: a fetch that fills it asks for every lane
   assign fwd_be    = (cls.cacheable && !cpu_wr) ? {LANES{1'b1}} : cpu_be;
   assign dir_wdata = fill_en ? sys_rdata : sys_wdata;

   wtq_bus_seq #(
      .ADDR_W (ADDR_W),
      .DATA_W (DATA_W)
   ) seq_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .accept    (accept),
      .in_addr   (cpu_addr),
      .in_wr     (cpu_wr),
      .in_kind   (cpu_kind),
      .in_be     (fwd_be),
      .in_wdata  (cpu_wdata),
      .in_fill   (cls.cacheable && !cpu_wr),
      .in_upd    (cls.cacheable && cpu_wr && hit),
      .sys_ack   (sys_ack),
      .idle      (idle),
      .sys_req   (sys_req),
      .sys_addr  (sys_addr),
      .sys_wr    (sys_wr),
      .sys_kind  (sys_kind),
      .sys_be    (sys_be),
      .sys_wdata (sys_wdata),
      .bus_done  (bus_done),
      .fill_en   (fill_en),
      .upd_en    (upd_en)
   );

   assign cpu_done  = (idle && cpu_req && cls.zero_wait) || bus_done;
   assign cpu_rdata = sys_req ? sys_rdata : lk_data;
endmodule

// File: rtl/wtq_checker.sv
module wtq_checker #(
   parameter int ADDR_W = 32,
   parameter int DATA_W = 32,
   localparam int LANES = DATA_W / 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              flush,
   input logic              cpu_req,
   input logic              cpu_wr,
   input logic [1:0]        cpu_kind,
   input logic [LANES-1:0]  cpu_be,
   input logic              dec_nocache,
   input logic              dec_local,
   input logic              cpu_done,
   input logic              sys_req,
   input logic              sys_ack,
   input logic [ADDR_W-1:0] sys_addr,
   input logic [LANES-1:0]  sys_be,
   input logic              sys_wr
);
   logic new_cyc;
   assign new_cyc = cpu_req && !sys_req;

   // R1
   zero_wait_no_bus_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cpu_done && !sys_req) |=> !sys_req);

   // R2
   fill_all_lanes_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (new_cyc && !dec_local && !dec_nocache && cpu_kind == 2'b00 && !cpu_wr && !cpu_done)
      |=> (sys_req && !sys_wr && sys_be == {LANES{1'b1}}));

   // R3
   write_be_copy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (new_cyc && !dec_local && cpu_wr) |=> (sys_req && sys_wr && sys_be == $past(cpu_be)));

   // R5
   non_mem_no_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (new_cyc && !dec_local && cpu_kind != 2'b00) |-> !cpu_done);

   // R6
   local_no_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (new_cyc && dec_local) |-> !cpu_done);

   // R6
   local_no_fwd_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (new_cyc && dec_local) |=> !sys_req);

   // R7
   write_waits_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (new_cyc && cpu_wr) |-> !cpu_done);

   // R8
   flush_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
      flush |=> !(cpu_done && !sys_req));

   // R9
   req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (sys_req && !sys_ack) |=> (sys_req && $stable(sys_addr) && $stable(sys_be) && $stable(sys_wr)));

   // R9
   ack_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (sys_req && sys_ack) |-> cpu_done);
endmodule

bind wt_cache_qualifier wtq_checker #(
   .ADDR_W (ADDR_W),
   .DATA_W (DATA_W)
) chk_i (
   .clk         (clk),
   .rst_n       (rst_n),
   .flush       (flush),
   .cpu_req     (cpu_req),
   .cpu_wr      (cpu_wr),
   .cpu_kind    (cpu_kind),
   .cpu_be      (cpu_be),
   .dec_nocache (dec_nocache),
   .dec_local   (dec_local),
   .cpu_done    (cpu_done),
   .sys_req     (sys_req),
   .sys_ack     (sys_ack),
   .sys_addr    (sys_addr),
   .sys_be      (sys_be),
   .sys_wr      (sys_wr)
);

// File: tb/wt_cache_qualifier_tb_top.sv
module wt_cache_qualifier_tb_top;
   localparam int ENTRIES = 16;
   localparam int IDX_W   = 4;
   localparam logic [31:0] BASE = 32'h8000_0000;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        flush = 1'b0;
   logic        cpu_req = 1'b0;
   logic [31:0] cpu_addr = '0;
   logic        cpu_wr = 1'b0;
   logic [1:0]  cpu_kind = '0;
   logic [3:0]  cpu_be = '0;
   logic [31:0] cpu_wdata = '0;
   logic        dec_nocache = 1'b0;
   logic        dec_local = 1'b0;
   logic        cpu_done;
   logic [31:0] cpu_rdata;
   logic        sys_req;
   logic [31:0] sys_addr;
   logic        sys_wr;
   logic [1:0]  sys_kind;
   logic [3:0]  sys_be;
   logic [31:0] sys_wdata;
   logic        sys_ack = 1'b0;
   logic [31:0] sys_rdata = '0;

   always #10 clk = ~clk;

   wt_cache_qualifier #(.ENTRIES(ENTRIES), .ADDR_W(32), .DATA_W(32)) dut_i (
      .clk(clk), .rst_n(rst_n), .flush(flush), .cpu_req(cpu_req), .cpu_addr(cpu_addr),
      .cpu_wr(cpu_wr), .cpu_kind(cpu_kind), .cpu_be(cpu_be), .cpu_wdata(cpu_wdata),
      .dec_nocache(dec_nocache), .dec_local(dec_local), .cpu_done(cpu_done),
      .cpu_rdata(cpu_rdata), .sys_req(sys_req), .sys_addr(sys_addr), .sys_wr(sys_wr),
      .sys_kind(sys_kind), .sys_be(sys_be), .sys_wdata(sys_wdata), .sys_ack(sys_ack),
      .sys_rdata(sys_rdata)
   );

   int n_chk = 0;
   int n_fail = 0;

   // bench model
   logic        m_valid [ENTRIES];
   logic [25:0] m_tag   [ENTRIES];
   logic [31:0] m_data  [ENTRIES];
   logic [31:0] mem [logic [29:0]];

   function automatic logic [31:0] mem_rd(input logic [31:0] a);
      if (mem.exists(a[31:2])) return mem[a[31:2]];
      return (a * 32'h9E37_79B1) ^ 32'h5A5A_0F0F;
   endfunction

   function automatic logic [31:0] merge(input logic [31:0] old, input logic [31:0] nw,
                                         input logic [3:0] be);
      logic [31:0] r = old;
      for (int b = 0; b < 4; b++) if (be[b]) r[b*8 +: 8] = nw[b*8 +: 8];
      return r;
   endfunction

   function automatic logic [31:0] mk_addr(input int tg, input int ix);
      return BASE + (32'(tg) << 6) + (32'(ix) << 2);
   endfunction

   function automatic logic m_hit(input logic [31:0] a);
      return m_valid[a[5:2]] && m_tag[a[5:2]] == a[31:6];
   endfunction

   task automatic clear_model();
      for (int e = 0; e < ENTRIES; e++) m_valid[e] = 1'b0;
   endtask

   task automatic chk(input logic ok, input string req, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
      end
   endtask

   task automatic run_cycle(input logic [1:0] kind, input logic wr, input logic [31:0] a,
                            input logic [3:0] be, input logic [31:0] wd,
                            input logic nc, input logic lc, input string req);
      logic cach, hit, zw, fwd;
      logic [31:0] exp_rd, wd_ret;
      logic [3:0]  exp_be;
      int dly;
      hit  = m_hit(a);
      cach = (kind == 2'b00) && !nc && !lc;
      zw   = cach && !wr && hit;
      fwd  = !lc && !zw;
      exp_rd = mem_rd(a);
      exp_be = (cach && !wr) ? 4'hF : be;

      @(negedge clk);
      cpu_req = 1'b1; cpu_kind = kind; cpu_wr = wr; cpu_addr = a; cpu_be = be;
      cpu_wdata = wd; dec_nocache = nc; dec_local = lc;
      #1;
      chk(cpu_done == zw, req, "done in request cycle", 32'(cpu_done), 32'(zw));
      if (zw) chk(cpu_rdata == m_data[a[5:2]], req, "hit data", cpu_rdata, m_data[a[5:2]]);
      @(negedge clk);
      cpu_req = 1'b0; dec_local = 1'b0; dec_nocache = 1'b0;
      #1;
      chk(sys_req == fwd, req, "sys_req after request", 32'(sys_req), 32'(fwd));
      if (fwd && sys_req) begin
         chk(sys_addr == a, req, "sys_addr", sys_addr, a);
         chk(sys_be == exp_be, req, "sys_be", 32'(sys_be), 32'(exp_be));
         chk(sys_wr == wr && sys_kind == kind, req, "sys_wr/kind",
             {29'd0, sys_wr, sys_kind}, {29'd0, wr, kind});
         if (wr) chk(sys_wdata == wd, req, "sys_wdata", sys_wdata, wd);
         dly = int'($urandom % 3);
         for (int i = 0; i < dly; i++) begin
            @(negedge clk); #1;
            chk(sys_req && sys_addr == a && cpu_done == 1'b0, "R9", "hold while waiting",
                {31'd0, sys_req}, 32'd1);
         end
         wd_ret = wr ? $urandom : exp_rd;
         sys_ack = 1'b1; sys_rdata = wd_ret;
         #1;
         chk(cpu_done == 1'b1, req, "done on ack", 32'(cpu_done), 32'd1);
         if (!wr) chk(cpu_rdata == exp_rd, req, "forwarded read data", cpu_rdata, exp_rd);
         @(negedge clk);
         sys_ack = 1'b0;
         #1;
         chk(sys_req == 1'b0, "R9", "request closed after ack", 32'(sys_req), 32'd0);
         if (wr) begin
            mem[a[31:2]] = merge(mem_rd(a), wd, be);
            if (cach && hit) m_data[a[5:2]] = merge(m_data[a[5:2]], wd, be);
         end else if (cach) begin
            m_valid[a[5:2]] = 1'b1; m_tag[a[5:2]] = a[31:6]; m_data[a[5:2]] = exp_rd;
         end
      end else if (lc) begin
         for (int i = 0; i < 3; i++) begin
            @(negedge clk); #1;
            chk(!sys_req && !cpu_done, req, "local cycle stays quiet",
                {30'd0, sys_req, cpu_done}, 32'd0);
         end
      end
   endtask

   task automatic pulse_flush();
      @(negedge clk); flush = 1'b1;
      @(negedge clk); flush = 1'b0;
      clear_model();
   endtask

   initial begin : watchdog
      repeat (150000) @(posedge clk);
      n_chk++; n_fail++;
      $display("FAIL watchdog expired actual=%h expected=%h", 32'd1, 32'd0);
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
   end

   initial begin : stim
      logic [31:0] a0, a0b, a1, a2;
      logic [31:0] v;
      void'($urandom(32'd2024));
      clear_model();
      a0  = mk_addr(1, 3);
      a0b = mk_addr(2, 3);
      a1  = mk_addr(0, 5);
      a2  = mk_addr(3, 7);
      repeat (3) @(negedge clk);
      #1;
      chk(!sys_req && !cpu_done, "R8", "reset state", {30'd0, sys_req, cpu_done}, 32'd0);
      rst_n = 1'b1;

      // R2 miss fills, then R1 hit
      run_cycle(2'b00, 1'b0, a0, 4'b0001, '0, 1'b0, 1'b0, "R2");
      run_cycle(2'b00, 1'b0, a0, 4'b0100, '0, 1'b0, 1'b0, "R1");
      // R7 write hit merges, R3 enables copied
      run_cycle(2'b00, 1'b1, a0, 4'b0011, 32'hDEAD_BEEF, 1'b0, 1'b0, "R7");
      run_cycle(2'b00, 1'b0, a0, 4'b1111, '0, 1'b0, 1'b0, "R7");
      // R7 write miss does not allocate; a0 still hits
      run_cycle(2'b00, 1'b1, a0b, 4'b1000, 32'h1234_5678, 1'b0, 1'b0, "R3");
      run_cycle(2'b00, 1'b0, a0, 4'b1111, '0, 1'b0, 1'b0, "R7");
      run_cycle(2'b00, 1'b0, a0b, 4'b1111, '0, 1'b0, 1'b0, "R7");
      // R10 eviction: a0b now owns index 3
      run_cycle(2'b00, 1'b0, a0, 4'b1111, '0, 1'b0, 1'b0, "R10");
      // R4 uncached read: no fill, cached line untouched
      run_cycle(2'b00, 1'b0, a1, 4'b0010, '0, 1'b1, 1'b0, "R4");
      run_cycle(2'b00, 1'b0, a1, 4'b0010, '0, 1'b0, 1'b0, "R4");
      run_cycle(2'b00, 1'b0, a1, 4'b0010, '0, 1'b1, 1'b0, "R4");
      run_cycle(2'b00, 1'b0, a1, 4'b0010, '0, 1'b0, 1'b0, "R4");
      // R5 non-memory kinds forwarded even to a cached word
      run_cycle(2'b01, 1'b0, a1, 4'b0001, '0, 1'b0, 1'b0, "R5");
      run_cycle(2'b10, 1'b0, a2, 4'b1111, '0, 1'b0, 1'b0, "R5");
      run_cycle(2'b11, 1'b1, a2, 4'b0000, 32'h0, 1'b0, 1'b0, "R5");
      run_cycle(2'b00, 1'b0, a2, 4'b1111, '0, 1'b0, 1'b0, "R5");
      // R6 local cycles do nothing
      run_cycle(2'b00, 1'b0, a1, 4'b1111, '0, 1'b0, 1'b1, "R6");
      run_cycle(2'b00, 1'b1, a1, 4'b1111, 32'hFFFF_0000, 1'b0, 1'b1, "R6");
      run_cycle(2'b00, 1'b0, a1, 4'b1111, '0, 1'b0, 1'b0, "R6");
      // R8 flush empties the directory
      pulse_flush();
      run_cycle(2'b00, 1'b0, a1, 4'b1111, '0, 1'b0, 1'b0, "R8");
      run_cycle(2'b00, 1'b0, a1, 4'b1111, '0, 1'b0, 1'b0, "R1");
      // R8 reset empties the directory
      @(negedge clk); rst_n = 1'b0;
      @(negedge clk); rst_n = 1'b1;
      clear_model();
      run_cycle(2'b00, 1'b0, a1, 4'b1111, '0, 1'b0, 1'b0, "R8");

      // random mix
      for (int n = 0; n < 600; n++) begin
         logic [1:0] k;
         logic w, nc, lc;
         logic [3:0] be;
         v  = $urandom;
         k  = (v[3:0] < 4'd12) ? 2'b00 : v[5:4];
         w  = v[6];
         nc = (v[10:7] < 4'd2);
         lc = (v[14:11] < 4'd1);
         be = v[19:16];
         if (w && be == 4'd0) be = 4'b0001;
         if (v[31:28] == 4'd0) pulse_flush();
         run_cycle(k, w, mk_addr(int'($urandom % 3), int'($urandom % 4)), be, $urandom,
                   nc, lc, "R1");
      end

      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
   end
endmodule